// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels gets the transfer engine next. Every channel presents a request line, an enable bit and a two-bit priority level set by software. On each arbitration point the block looks only at channels that are both enabled and requesting. It picks the highest priority level present among them. If more than one channel sits at that level, the channel with the smallest index wins.

Once a channel is granted, the grant stays with it until the engine reports, through a single item-done strobe, that the current data item is finished. Only then does arbitration run again. A higher-priority request that arrives in the meantime never interrupts the item being moved.

The result leaves the block as a one-hot grant vector, the binary index of the winner and a valid flag. The reset input may be asserted at any time. Its release is synchronised to the clock inside the block.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted, and until the first arbitration after its release, `gnt_o` is all zeros, `gnt_idx_o` is 0 and `gnt_valid_o` is low.
- R2: A channel is eligible when both its request bit and its enable bit are high. Its priority is the 2-bit field `prio_i[2c+1:2c]`, where 00 is low, 01 is medium, 10 is high and 11 is very high. The channel granted is always one at the highest level present among the eligible channels.
- R3: When several eligible channels share the highest level, the one with the lowest index is granted.
- R4: A channel whose enable bit is low is never granted, even when its request bit is high.
- R5: When arbitration runs with no eligible channel, `gnt_o` becomes all zeros, `gnt_idx_o` becomes 0 and `gnt_valid_o` becomes low.
- R6: While a grant is active and `item_done_i` is low, `gnt_o` and `gnt_idx_o` stay unchanged, whatever happens on the request, enable and priority inputs.
- R7: Arbitration runs at a rising clock edge when no grant is active, or when a grant is active and `item_done_i` is high. The new result appears on the outputs one clock after the inputs are sampled. The channel that just finished may win again.
- R8: `gnt_o` has at most one bit set, `gnt_valid_o` is high exactly when one bit is set, and `gnt_idx_o` is the position of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| req_i | input | NUM_CH | Per-channel transfer request |
| en_i | input | NUM_CH | Per-channel enable; a low bit masks that channel out |
| prio_i | input | NUM_CH*PRIO_W | Per-channel priority level; channel c occupies bits [PRIO_W*c +: PRIO_W] |
| item_done_i | input | 1 | The granted channel has finished its current item |
| gnt_o | output | NUM_CH | One-hot grant |
| gnt_idx_o | output | IDX_W | Binary index of the granted channel |
| gnt_valid_o | output | 1 | A grant is active |

## Verification
Several rules are checked on every cycle by assertions. They cover the one-hot shape of the grant and its agreement with the index and valid flag. They cover the hold of a grant while no item-done arrives, and that every new grant goes to a channel that was eligible one cycle earlier. They also cover that the winner sits at the top eligible level with no lower-numbered channel tied with it, and that an arbitration with nothing eligible gives an empty grant.

Some behaviour can only be shown by the bench's scenarios. These include the reset outputs before the first arbitration, and a very-high request arriving mid-item and waiting for item-done. They also include a masked channel at the top level losing to a low-priority enabled one, item-done while idle having no effect, and the finishing channel winning again.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Software priority levels; numerically larger means more urgent.
  typedef enum logic [1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_e;

  localparam int unsigned PRIO_BITS   = $bits(prio_e);
  localparam int unsigned DEF_CHANNELS = 7;

endpackage

// File: rtl/dma_arb_rst_sync.sv
// Asynchronous assert, synchronous release.
module dma_arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/dma_arb_level.sv
// Finds the highest priority level among eligible channels and flags
// every eligible channel sitting at that level.
module dma_arb_level #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned PRIO_W = 2
) (
  input  logic [NUM_CH-1:0]        elig_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic [NUM_CH-1:0]        top_o
);

  localparam int unsigned LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0][NUM_CH-1:0] at_level;
  logic [LEVELS-1:0]             level_hit;
  logic [PRIO_W-1:0]             top_level;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign at_level[l][c] = elig_i[c] &&
                              (prio_i[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign level_hit[l] = |at_level[l];
  end

  // Later (higher) levels override earlier ones.
  always_comb begin
    top_level = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level_hit[l]) begin
        top_level = PRIO_W'(l);
      end
    end
  end

  assign top_o = at_level[top_level];

endmodule

// File: rtl/dma_arb_lowfirst.sv
// Keeps only the lowest-index candidate and encodes its position.
module dma_arb_lowfirst #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] cand_i,
  output logic [NUM_CH-1:0] win_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [NUM_CH-1:0] lower_seen;

  assign lower_seen[0] = 1'b0;
  for (genvar c = 1; c < NUM_CH; c++) begin : g_prefix
    assign lower_seen[c] = lower_seen[c-1] | cand_i[c-1];
  end

  assign win_o = cand_i & ~lower_seen;

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (win_o[c]) begin
        idx_o = idx_o | IDX_W'(c);
      end
    end
  end

endmodule

// File: rtl/dma_arb_hold.sv
// Grant register: loads a new decision only when idle or when the
// holder reports its item finished.
module dma_arb_hold #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [NUM_CH-1:0] win_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);

  logic [NUM_CH-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              busy;
  logic              load_en;

  assign busy    = |gnt_q;
  assign load_en = !busy || done_i;

  always_comb begin
    gnt_d = gnt_q;
    idx_d = idx_q;
    if (load_en) begin
      gnt_d = win_i;
      idx_d = win_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      idx_q <= '0;
    end else if (load_en) begin
      gnt_q <= gnt_d;
      idx_q <= idx_d;
    end
  end

  assign gnt_o   = gnt_q;
  assign idx_o   = idx_q;
  assign valid_o = busy;

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int unsigned NUM_CH = dma_arb_pkg::DEF_CHANNELS,
  parameter int unsigned PRIO_W = dma_arb_pkg::PRIO_BITS,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     item_done_i,
  output logic [NUM_CH-1:0]        gnt_o,
  output logic [IDX_W-1:0]         gnt_idx_o,
  output logic                     gnt_valid_o
);

  logic              rst_n_sync;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] top_cand;
  logic [NUM_CH-1:0] winner;
  logic [IDX_W-1:0]  winner_idx;

  dma_arb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n_sync)
  );

  assign eligible = req_i & en_i;

  dma_arb_level #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_level (
    .elig_i(eligible),
    .prio_i(prio_i),
    .top_o (top_cand)
  );

  dma_arb_lowfirst #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_lowfirst (
    .cand_i(top_cand),
    .win_o (winner),
    .idx_o (winner_idx)
  );

  dma_arb_hold #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .done_i   (item_done_i),
    .win_i    (winner),
    .win_idx_i(winner_idx),
    .gnt_o    (gnt_o),
    .idx_o    (gnt_idx_o),
    .valid_o  (gnt_valid_o)
  );

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH-1:0]        req_i,
  input logic [NUM_CH-1:0]        en_i,
  input logic [NUM_CH*PRIO_W-1:0] prio_i,
  input logic                     item_done_i,
  input logic [NUM_CH-1:0]        gnt_o,
  input logic [IDX_W-1:0]         gnt_idx_o,
  input logic                     gnt_valid_o
);

  logic [NUM_CH-1:0]        elig_q;
  logic [NUM_CH*PRIO_W-1:0] prio_q;
  logic                     arb_q;
  logic [PRIO_W-1:0]        max_q;
  logic [PRIO_W-1:0]        win_prio;
  logic                     lower_tie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= '0;
      prio_q <= '0;
      arb_q  <= 1'b0;
    end else begin
      elig_q <= req_i & en_i;
      prio_q <= prio_i;
      arb_q  <= !gnt_valid_o || item_done_i;
    end
  end

  always_comb begin
    max_q = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (elig_q[c] && prio_q[c*PRIO_W +: PRIO_W] > max_q) begin
        max_q = prio_q[c*PRIO_W +: PRIO_W];
      end
    end
  end

  assign win_prio = prio_q[int'(gnt_idx_o)*PRIO_W +: PRIO_W];

  always_comb begin
    lower_tie = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c < int'(gnt_idx_o) && elig_q[c] &&
          prio_q[c*PRIO_W +: PRIO_W] == max_q) begin
        lower_tie = 1'b1;
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0))) else $error("onehot"); // R8

  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> gnt_o[gnt_idx_o]) else $error("idx"); // R8

  AST_HOLD_MID_ITEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !item_done_i) |=> ($stable(gnt_o) && $stable(gnt_idx_o))) else $error("hold"); // R6

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o || item_done_i) |=> ((gnt_o & ~($past(req_i) & $past(en_i))) == '0)) else $error("elig"); // R4

  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!gnt_valid_o || item_done_i) && ((req_i & en_i) == '0)) |=> (!gnt_valid_o && gnt_idx_o == '0)) else $error("idle"); // R5

  AST_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_q && elig_q != '0) |-> (gnt_valid_o && win_prio == max_q)) else $error("level"); // R2

  AST_TIE_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_q && gnt_valid_o) |-> !lower_tie) else $error("tie"); // R3

endmodule

bind dma_chan_arbiter dma_arb_chk #(
  .NUM_CH(NUM_CH),
  .PRIO_W(PRIO_W),
  .IDX_W (IDX_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_sync),
  .req_i      (req_i),
  .en_i       (en_i),
  .prio_i     (prio_i),
  .item_done_i(item_done_i),
  .gnt_o      (gnt_o),
  .gnt_idx_o  (gnt_idx_o),
  .gnt_valid_o(gnt_valid_o)
);

// File: tb/dma_chan_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_chan_arbiter_tb_top;
  import dma_arb_pkg::*;

  localparam int NCH = 7;
  localparam int PW  = 2;
  localparam int IW  = 3;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  req;
  logic [NCH-1:0]  en;
  logic [NCH*PW-1:0] prio;
  logic            done;
  logic [NCH-1:0]  gnt;
  logic [IW-1:0]   gnt_idx;
  logic            gnt_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int m_idx    = 0;
  bit m_valid  = 0;

  dma_chan_arbiter #(.NUM_CH(NCH), .PRIO_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .prio_i(prio),
    .item_done_i(done), .gnt_o(gnt), .gnt_idx_o(gnt_idx), .gnt_valid_o(gnt_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int pick(logic [NCH-1:0] r, logic [NCH-1:0] e, logic [NCH*PW-1:0] p);
    int best = -1;
    int bp   = -1;
    for (int c = 0; c < NCH; c++) begin
      if (r[c] && e[c] && int'(p[c*PW +: PW]) > bp) begin
        best = c;
        bp   = int'(p[c*PW +: PW]);
      end
    end
    return best;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: applies inputs, advances the model to the state
  // after the next rising edge, then compares at the following negedge.
  task automatic step(string tag, logic [NCH-1:0] r, logic [NCH-1:0] e,
                      logic [NCH*PW-1:0] p, logic d);
    int w;
    req = r; en = e; prio = p; done = d;
    if (!m_valid || d) begin
      w = pick(r, e, p);
      m_valid = (w >= 0);
      m_idx   = m_valid ? w : 0;
    end
    @(negedge clk);
    chk(tag, int'(gnt), m_valid ? (1 << m_idx) : 0);
    chk(tag, int'(gnt_idx), m_idx);
    chk("R8", int'(gnt_valid), int'(m_valid));
    chk("R8", int'($countones(gnt) <= 1), 1);
  endtask

  function automatic logic [NCH*PW-1:0] all_prio(prio_e v);
    logic [NCH*PW-1:0] p;
    for (int c = 0; c < NCH; c++) p[c*PW +: PW] = v;
    return p;
  endfunction

  initial begin
    logic [NCH*PW-1:0] p;
    logic [NCH-1:0] rr, ee;
    int dummy;
    dummy = $urandom(32'h5eed_0042);
    rst_n = 1'b0; req = '0; en = '0; prio = '0; done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", int'(gnt), 0);
    chk("R1", int'(gnt_valid), 0);
    chk("R1", int'(gnt_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", int'(gnt_valid), 0);

    step("R5", '0, '1, '0, 1'b0);
    step("R4", 7'b0000100, 7'b1111011, all_prio(PRIO_VHIGH), 1'b0);
    step("R3", 7'b1111111, '1, all_prio(PRIO_LOW), 1'b0);
    step("R7", 7'b1111111, '1, all_prio(PRIO_LOW), 1'b1);
    step("R3", 7'b1010100, '1, all_prio(PRIO_MED), 1'b1);
    p = all_prio(PRIO_LOW);
    p[6*PW +: PW] = PRIO_VHIGH;
    step("R2", 7'b1000001, '1, p, 1'b1);
    p = all_prio(PRIO_LOW);
    p[1*PW +: PW] = PRIO_VHIGH;
    step("R6", 7'b0000010, '1, p, 1'b0);
    step("R6", 7'b0000010, '1, p, 1'b0);
    step("R7", 7'b0000010, '1, p, 1'b1);
    p = all_prio(PRIO_LOW);
    p[5*PW +: PW] = PRIO_VHIGH;
    step("R4", 7'b0101000, 7'b1011111, p, 1'b1);
    step("R5", '0, '1, p, 1'b1);
    step("R7", '0, '1, p, 1'b1);
    p = all_prio(PRIO_HIGH);
    p[0*PW +: PW] = PRIO_MED;
    step("R2", 7'b0010001, '1, p, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      rr = NCH'($urandom);
      ee = NCH'($urandom) | NCH'($urandom);
      for (int c = 0; c < NCH; c++) p[c*PW +: PW] = PW'($urandom);
      step("R2", rr, ee, p, ($urandom % 3) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule